// File: doc/BRIEF.md
# DMA Channel Sequencer with Descriptor Chaining

This block sequences a single DMA channel. It decides which bytes move and when, and it leaves the actual copying to an external data-mover engine. Software programs the channel through a small register port. In direct mode the channel runs one transfer from the programmed count, source and destination. In chaining mode it fetches a four-word descriptor from memory through a simple word-read port, runs that segment, and then follows the descriptor's link to the next one.

The sequencer splits every segment into mover requests of at most `CHUNK_BYTES` bytes. After each request finishes, it advances the source, destination and remaining count. Software can stop the channel between requests by clearing the start bit. An error on a descriptor fetch or on a mover request also stops it. Because the count and addresses always show the progress so far, setting start again continues from where the channel stopped. Each segment carries a cache-snoop attribute to the mover.

Top module: `dma_chan_seq`

## Requirements
- R1: Writing 1 to mode bit 0 (start) while the channel is idle begins a transfer. Mode bit 1 selects chaining (1) or direct (0). Status bit 0 (busy) reads 1 while the channel is working.
- R2: A non-zero count is moved as a series of mover requests. Each request has length min(count, CHUNK_BYTES). After each successful request the source and destination advance by the length and the count drops by it. When the count reaches 0 the transfer ends: the start bit clears, busy drops and status bit 1 (segment done) sets. A start with count 0 in direct mode issues no request and clears the start bit.
- R3: In chaining mode, when the count is 0, the channel reads a descriptor at the next-descriptor register with bits 4:0 masked off. It reads four words: offset +0 source, +4 destination, +8 next link, +12 byte count. It loads all four only after the last word arrives, and only then starts the segment.
- R4: When a chained segment finishes, the channel fetches the descriptor at the loaded link, unless bit 0 of that link is 1. A link with bit 0 set marks the just-finished segment as the last one, and the channel stops.
- R5: On each descriptor load, the current-descriptor register becomes the fetch base, with bit 1 set to bit 1 of the next-descriptor register at fetch time. The mover's snoop output always equals bit 1 of the current-descriptor register. In direct mode software programs that bit.
- R6: Clearing the start bit while the channel is busy lets the request in flight finish. No further request is issued, busy drops, and the count and addresses reflect the moved bytes.
- R7: Setting start again after a stop with a non-zero count continues with the remaining bytes. Registers written while idle define a new transfer.
- R8: A descriptor fetch that returns a bus error sets status bit 2 (error) and clears start. It issues no mover request and changes no count or address register.
- R9: A mover request that reports an error sets the error flag and clears start. The count and addresses are not advanced.
- R10: The error and segment-done flags are sticky and clear when software writes 1 to their status bit. A hardware set in the same cycle as a clear wins.
- R11: Writes to the count, source, destination and both descriptor registers are ignored while busy.
- R12: A mover request stays asserted with stable source, destination, length and snoop until done. The memory and mover ports are never requested at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 mode, 1 status, 2 count, 3 source, 4 destination, 5 current descriptor, 6 next descriptor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read completion |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Bus error, valid with mem_ack |
| mv_req | output | 1 | Mover request, held until mv_done |
| mv_src | output | 32 | Request source address |
| mv_dst | output | 32 | Request destination address |
| mv_len | output | 32 | Request length in bytes |
| mv_snoop | output | 1 | Snoop attribute of the current segment |
| mv_done | input | 1 | Mover completion pulse |
| mv_err | input | 1 | Mover error, valid with mv_done |

## Verification
Two events can land on the same clock edge: software's write-1-to-clear of the segment-done flag, and the hardware completion of the final request of a segment. The bench watches the mover's done pulse on a falling edge and places the status write so that it is captured on the very rising edge where the sequencer retires the final chunk. The flag must then read 1, because the set wins. A second overlap is a stop request that arrives while a chunk is in flight. It is judged by the count left behind and by how many requests were logged.

// File: rtl/dma_seq_pkg.sv
// Shared definitions for the DMA channel sequencer.
// Assumes 32-bit registers and byte addressing.
package dma_seq_pkg;
    localparam int WORD_W = 32;

    localparam logic [2:0] RA_MODE  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_COUNT = 3'd2;
    localparam logic [2:0] RA_SRC   = 3'd3;
    localparam logic [2:0] RA_DST   = 3'd4;
    localparam logic [2:0] RA_CUR   = 3'd5;
    localparam logic [2:0] RA_NEXT  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MOVE  = 2'd2,
        ST_NEXT  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/dma_seq_sizer.sv
// Chunk sizer: returns the length of the next mover request.
// That length is the remaining count, capped at CHUNK_BYTES.
// Assumes CHUNK_BYTES is at least 1.
module dma_seq_sizer #(
    parameter int CHUNK_BYTES = 16
) (
    input  logic [dma_seq_pkg::WORD_W-1:0] remain,
    output logic [dma_seq_pkg::WORD_W-1:0] chunk_len,
    output logic                           is_last
);
    localparam logic [dma_seq_pkg::WORD_W-1:0] CAP = dma_seq_pkg::WORD_W'(CHUNK_BYTES);

    // Pick the capped length and flag the final chunk.
    always_comb begin
        chunk_len = (remain > CAP) ? CAP : remain;
        is_last   = (remain <= CAP);
    end
endmodule

// File: rtl/dma_seq_regs.sv
// Register file of the channel: mode, sticky status, count, addresses, descriptors.
// Hardware updates take priority over software writes.
// Configuration writes are dropped while the channel is busy.
module dma_seq_regs
    import dma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              hw_stop,
    input  logic              hw_seg,
    input  logic              hw_err,
    input  logic              hw_adv,
    input  logic [WORD_W-1:0] adv_len,
    input  logic              hw_load,
    input  logic [WORD_W-1:0] ld_src,
    input  logic [WORD_W-1:0] ld_dst,
    input  logic [WORD_W-1:0] ld_next,
    input  logic [WORD_W-1:0] ld_count,
    input  logic [WORD_W-1:0] ld_cur,
    output logic              start,
    output logic              chain,
    output logic [WORD_W-1:0] cnt,
    output logic [WORD_W-1:0] src,
    output logic [WORD_W-1:0] dst,
    output logic              cur_snoop,
    output logic [WORD_W-1:0] nxt
);
    logic [WORD_W-1:0] cur;
    logic              seg_flag, err_flag;
    logic              cfg_wr, stat_wr;

    // Decode the software write strobes.
    always_comb begin
        cfg_wr  = reg_wr && !busy;
        stat_wr = reg_wr && (reg_addr == RA_STAT);
    end

    // Mode register: software sets start and chain; hardware clears start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            chain <= 1'b0;
        end else if (hw_stop) begin
            start <= 1'b0;
        end else if (reg_wr && reg_addr == RA_MODE) begin
            start <= reg_wdata[0];
            chain <= reg_wdata[1];
        end
    end

    // Sticky flags: a hardware set wins over a write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            seg_flag <= hw_seg | (seg_flag & ~(stat_wr & reg_wdata[1]));
            err_flag <= hw_err | (err_flag & ~(stat_wr & reg_wdata[2]));
        end
    end

    // Transfer registers: descriptor load, chunk advance, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            src <= '0;
            dst <= '0;
            cur <= '0;
            nxt <= '0;
        end else if (hw_load) begin
            cnt <= ld_count;
            src <= ld_src;
            dst <= ld_dst;
            cur <= ld_cur;
            nxt <= ld_next;
        end else if (hw_adv) begin
            cnt <= cnt - adv_len;
            src <= src + adv_len;
            dst <= dst + adv_len;
        end else if (cfg_wr) begin
            case (reg_addr)
                RA_COUNT: cnt <= reg_wdata;
                RA_SRC:   src <= reg_wdata;
                RA_DST:   dst <= reg_wdata;
                RA_CUR:   cur <= reg_wdata;
                RA_NEXT:  nxt <= reg_wdata;
                default:  ;
            endcase
        end
    end

    // Read mux and snoop attribute of the segment being run.
    always_comb begin
        cur_snoop = cur[1];
        case (reg_addr)
            RA_MODE:  reg_rdata = {30'b0, chain, start};
            RA_STAT:  reg_rdata = {29'b0, err_flag, seg_flag, busy};
            RA_COUNT: reg_rdata = cnt;
            RA_SRC:   reg_rdata = src;
            RA_DST:   reg_rdata = dst;
            RA_CUR:   reg_rdata = cur;
            RA_NEXT:  reg_rdata = nxt;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_seq_ctrl.sv
// Channel control FSM: fetches descriptors, issues capped mover requests,
// follows the chain, and stops on a cleared start bit or on an error.
// Assumes the memory port answers one word per request with mem_ack,
// and the mover answers each request with a single mv_done pulse.
module dma_seq_ctrl
    import dma_seq_pkg::*;
#(
    parameter int CHUNK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chain,
    input  logic [WORD_W-1:0] cnt,
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] dst,
    input  logic              cur_snoop,
    input  logic [WORD_W-1:0] nxt,
    output logic              busy,
    output logic              hw_stop,
    output logic              hw_seg,
    output logic              hw_err,
    output logic              hw_adv,
    output logic [WORD_W-1:0] adv_len,
    output logic              hw_load,
    output logic [WORD_W-1:0] ld_src,
    output logic [WORD_W-1:0] ld_dst,
    output logic [WORD_W-1:0] ld_next,
    output logic [WORD_W-1:0] ld_count,
    output logic [WORD_W-1:0] ld_cur,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              mv_req,
    output logic [WORD_W-1:0] mv_src,
    output logic [WORD_W-1:0] mv_dst,
    output logic [WORD_W-1:0] mv_len,
    output logic              mv_snoop,
    input  logic              mv_done,
    input  logic              mv_err
);
    localparam logic [WORD_W-1:0] DESC_MASK = ~WORD_W'(31);

    seq_state_t        state, state_n;
    logic [1:0]        idx;
    logic [WORD_W-1:0] sh_src, sh_dst, sh_next;
    logic [WORD_W-1:0] chunk_len;
    logic              last_chunk;
    logic [WORD_W-1:0] desc_base;
    logic              want_fetch;

    dma_seq_sizer #(.CHUNK_BYTES(CHUNK_BYTES)) u_sizer (
        .remain    (cnt),
        .chunk_len (chunk_len),
        .is_last   (last_chunk)
    );

    // Port outputs and descriptor load values.
    always_comb begin
        desc_base  = nxt & DESC_MASK;
        want_fetch = chain && !nxt[0];
        busy       = (state != ST_IDLE);
        mem_req    = (state == ST_FETCH);
        mem_addr   = desc_base | {{(WORD_W-4){1'b0}}, idx, 2'b00};
        mv_req     = (state == ST_MOVE);
        mv_src     = src;
        mv_dst     = dst;
        mv_len     = chunk_len;
        mv_snoop   = cur_snoop;
        adv_len    = chunk_len;
        ld_src     = sh_src;
        ld_dst     = sh_dst;
        ld_next    = sh_next;
        ld_count   = mem_rdata;
        ld_cur     = desc_base | {{(WORD_W-2){1'b0}}, nxt[1], 1'b0};
    end

    // Next-state and register-update decisions.
    always_comb begin
        state_n = state;
        hw_stop = 1'b0;
        hw_seg  = 1'b0;
        hw_err  = 1'b0;
        hw_adv  = 1'b0;
        hw_load = 1'b0;
        case (state)
            ST_IDLE, ST_NEXT: begin
                if (!start)              state_n = ST_IDLE;
                else if (cnt != '0)      state_n = ST_MOVE;
                else if (want_fetch)     state_n = ST_FETCH;
                else begin
                    hw_stop = 1'b1;
                    state_n = ST_IDLE;
                end
            end
            ST_FETCH: begin
                if (mem_ack && mem_err) begin
                    hw_err  = 1'b1;
                    hw_stop = 1'b1;
                    state_n = ST_IDLE;
                end else if (mem_ack && idx == 2'd3) begin
                    hw_load = 1'b1;
                    state_n = ST_NEXT;
                end
            end
            ST_MOVE: begin
                if (mv_done && mv_err) begin
                    hw_err  = 1'b1;
                    hw_stop = 1'b1;
                    state_n = ST_IDLE;
                end else if (mv_done) begin
                    hw_adv  = 1'b1;
                    hw_seg  = last_chunk;
                    state_n = ST_NEXT;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Descriptor word index and shadow capture of the first three words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx     <= 2'd0;
            sh_src  <= '0;
            sh_dst  <= '0;
            sh_next <= '0;
        end else if (state == ST_FETCH && mem_ack) begin
            if (mem_err) begin
                idx <= 2'd0;
            end else begin
                idx <= idx + 2'd1;
                case (idx)
                    2'd0:    sh_src  <= mem_rdata;
                    2'd1:    sh_dst  <= mem_rdata;
                    2'd2:    sh_next <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_chan_seq.sv
// Top of the DMA channel sequencer: register file plus control FSM.
// Moves no data itself; it drives an external mover and a descriptor read port.
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int CHUNK_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              mv_req,
    output logic [WORD_W-1:0] mv_src,
    output logic [WORD_W-1:0] mv_dst,
    output logic [WORD_W-1:0] mv_len,
    output logic              mv_snoop,
    input  logic              mv_done,
    input  logic              mv_err
);
    logic              start, chain, cur_snoop, busy;
    logic              hw_stop, hw_seg, hw_err, hw_adv, hw_load;
    logic [WORD_W-1:0] cnt, src, dst, nxt, adv_len;
    logic [WORD_W-1:0] ld_src, ld_dst, ld_next, ld_count, ld_cur;

    dma_seq_regs u_regs (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .hw_stop, .hw_seg, .hw_err, .hw_adv, .adv_len,
        .hw_load, .ld_src, .ld_dst, .ld_next, .ld_count, .ld_cur,
        .start, .chain, .cnt, .src, .dst, .cur_snoop, .nxt
    );

    dma_seq_ctrl #(.CHUNK_BYTES(CHUNK_BYTES)) u_ctrl (
        .clk, .rst_n, .start, .chain, .cnt, .src, .dst, .cur_snoop, .nxt,
        .busy, .hw_stop, .hw_seg, .hw_err, .hw_adv, .adv_len,
        .hw_load, .ld_src, .ld_dst, .ld_next, .ld_count, .ld_cur,
        .mem_req, .mem_addr, .mem_ack, .mem_rdata, .mem_err,
        .mv_req, .mv_src, .mv_dst, .mv_len, .mv_snoop, .mv_done, .mv_err
    );
endmodule

// File: rtl/dma_seq_chk.sv
// Protocol checker for the channel sequencer, attached by bind.
// Observes only the memory and mover ports.
module dma_seq_chk #(
    parameter int CHUNK_BYTES = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        mem_err,
    input logic        mv_req,
    input logic [31:0] mv_src,
    input logic [31:0] mv_dst,
    input logic [31:0] mv_len,
    input logic        mv_snoop,
    input logic        mv_done
);
    // Only one of the two request ports is active at a time.
    assert_one_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, mv_req}));

    // A request without done is still there next cycle, unchanged.
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_req && !mv_done) |=> (mv_req && $stable(mv_src) && $stable(mv_dst)
                                  && $stable(mv_len) && $stable(mv_snoop)));

    // Every request length is non-zero and capped.
    assert_len_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mv_req |-> (mv_len != 32'd0 && mv_len <= 32'(CHUNK_BYTES)));

    // Descriptor reads are word addresses.
    assert_word_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // A failed fetch never leads straight into a mover request.
    assert_fetch_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> !mv_req);
endmodule

bind dma_chan_seq dma_seq_chk #(.CHUNK_BYTES(CHUNK_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_err  (mem_err),
    .mv_req   (mv_req),
    .mv_src   (mv_src),
    .mv_dst   (mv_dst),
    .mv_len   (mv_len),
    .mv_snoop (mv_snoop),
    .mv_done  (mv_done)
);

// File: tb/dma_chan_seq_test.sv
// Self-checking bench for dma_chan_seq with a mover model and a descriptor memory model.
module dma_chan_seq_test;
    localparam int CHUNK = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_ack, mem_err;
    logic [31:0] mem_addr, mem_rdata;
    logic        mv_req, mv_snoop, mv_done, mv_err;
    logic [31:0] mv_src, mv_dst, mv_len;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // Model controls, driven by the main sequence only.
    int          mv_delay = 2;
    bit          inj_err = 1'b0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] mem [32];

    // Mover log, written by the mover model only.
    int          log_n;
    logic [31:0] log_len [64];
    logic [31:0] log_src [64];
    logic        log_snp [64];
    int          mv_wait;

    always #5 clk = ~clk;

    dma_chan_seq #(.CHUNK_BYTES(CHUNK)) uut (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req, .mem_addr, .mem_ack, .mem_rdata, .mem_err,
        .mv_req, .mv_src, .mv_dst, .mv_len, .mv_snoop, .mv_done, .mv_err
    );

    // Mover model: answers each request after mv_delay cycles and logs it.
    always @(posedge clk) begin
        if (!rst_n) begin
            mv_done <= 1'b0;
            mv_err  <= 1'b0;
            mv_wait <= 0;
            log_n   <= 0;
        end else begin
            mv_done <= 1'b0;
            mv_err  <= 1'b0;
            if (mv_req && !mv_done) begin
                if (mv_wait >= mv_delay) begin
                    mv_done <= 1'b1;
                    mv_err  <= inj_err;
                    mv_wait <= 0;
                    if (log_n < 64) begin
                        log_len[log_n] <= mv_len;
                        log_src[log_n] <= mv_src;
                        log_snp[log_n] <= mv_snoop;
                    end
                    log_n <= log_n + 1;
                end else begin
                    mv_wait <= mv_wait + 1;
                end
            end
        end
    end

    // Descriptor memory model: one word per request, one cycle later.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_err   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr[6:2]];
                mem_err   <= (mem_addr == err_addr);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3000; k++) begin
            rd(3'd1, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    // Direct-mode vectors: count, expected request count, expected last length.
    localparam logic [31:0] V_CNT [6] = '{32'd0, 32'd1, 32'd16, 32'd17, 32'd40, 32'd64};
    localparam int          V_REQ [6] = '{0, 1, 1, 2, 3, 4};
    localparam logic [31:0] V_LAST[6] = '{32'd0, 32'd1, 32'd16, 32'd1, 32'd8, 32'd16};

    // Watchdog: a hang counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base;

        for (int i = 0; i < 32; i++) mem[i] = '0;
        // Chain: D0 at 0x00, D1 at 0x20, D2 at 0x40 (last), D3 at 0x60 (read error on +4).
        mem[0]  = 32'h0000_1000; mem[1]  = 32'h0000_2000; mem[2]  = 32'h0000_0022; mem[3]  = 32'd20;
        mem[8]  = 32'h0000_3000; mem[9]  = 32'h0000_4000; mem[10] = 32'h0000_0040; mem[11] = 32'd8;
        mem[16] = 32'h0000_5000; mem[17] = 32'h0000_6000; mem[18] = 32'h0000_0001; mem[19] = 32'd4;
        mem[24] = 32'h0000_7000; mem[25] = 32'h0000_7100; mem[26] = 32'h0000_0001; mem[27] = 32'd8;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        rd(3'd1, v); chk("R1 reset status", v, 32'h0);
        rd(3'd2, v); chk("R2 reset count", v, 32'h0);
        chk("R12 reset mover idle", {31'b0, mv_req}, 32'h0);
        chk("R12 reset memory idle", {31'b0, mem_req}, 32'h0);

        // Direct-mode vector walk (R1, R2, R5, R7).
        for (int i = 0; i < 6; i++) begin
            wr(3'd1, 32'h2);
            wr(3'd2, V_CNT[i]);
            wr(3'd3, 32'h1000_0000 + 32'(i) * 32'h1000);
            wr(3'd4, 32'h2000_0000);
            wr(3'd5, (i % 2 == 1) ? 32'h2 : 32'h0);
            base = log_n;
            wr(3'd0, 32'h1);
            wait_idle();
            chk("R2 request count", 32'(log_n - base), 32'(V_REQ[i]));
            if (V_REQ[i] > 0) begin
                chk("R2 last length", log_len[log_n-1], V_LAST[i]);
                chk("R5 direct snoop", {31'b0, log_snp[log_n-1]}, (i % 2 == 1) ? 32'h1 : 32'h0);
            end
            rd(3'd2, v); chk("R2 count drained", v, 32'h0);
            rd(3'd3, v); chk("R2 source advanced", v, 32'h1000_0000 + 32'(i) * 32'h1000 + V_CNT[i]);
            rd(3'd0, v); chk("R2 start cleared", v & 32'h1, 32'h0);
            rd(3'd1, v); chk("R2 segment flag", v & 32'h2, (V_CNT[i] != 0) ? 32'h2 : 32'h0);
        end

        // Chaining mode over three descriptors (R3, R4, R5).
        wr(3'd6, 32'h0000_0000);
        base = log_n;
        wr(3'd0, 32'h3);
        wait_idle();
        chk("R4 chain request count", 32'(log_n - base), 32'd4);
        chk("R3 D0 first length", log_len[base], 32'd16);
        chk("R3 D0 source", log_src[base], 32'h1000);
        chk("R3 D0 tail length", log_len[base+1], 32'd4);
        chk("R5 D0 snoop", {31'b0, log_snp[base]}, 32'h0);
        chk("R3 D1 source", log_src[base+2], 32'h3000);
        chk("R5 D1 snoop", {31'b0, log_snp[base+2]}, 32'h1);
        chk("R4 D2 length", log_len[base+3], 32'd4);
        chk("R5 D2 snoop", {31'b0, log_snp[base+3]}, 32'h0);
        rd(3'd5, v); chk("R5 current descriptor", v, 32'h0000_0040);
        rd(3'd6, v); chk("R4 last link", v, 32'h0000_0001);
        rd(3'd3, v); chk("R3 final source", v, 32'h5004);

        // Fetch bus error (R8), then write-1-to-clear of error (R10).
        wr(3'd6, 32'h0000_0060);
        err_addr = 32'h0000_0064;
        base = log_n;
        wr(3'd0, 32'h3);
        wait_idle();
        err_addr = 32'hFFFF_FFFF;
        chk("R8 no request after fetch error", 32'(log_n - base), 32'd0);
        rd(3'd1, v); chk("R8 error flag", v & 32'h4, 32'h4);
        rd(3'd0, v); chk("R8 start cleared", v & 32'h1, 32'h0);
        rd(3'd3, v); chk("R8 source untouched", v, 32'h5004);
        rd(3'd2, v); chk("R8 count untouched", v, 32'h0);
        wr(3'd1, 32'h4);
        rd(3'd1, v); chk("R10 error cleared", v & 32'h4, 32'h0);

        // Mover error (R9), then resume after it (R7).
        wr(3'd0, 32'h0);
        wr(3'd2, 32'd32);
        wr(3'd3, 32'h0000_0100);
        inj_err = 1'b1;
        wr(3'd0, 32'h1);
        wait_idle();
        inj_err = 1'b0;
        rd(3'd1, v); chk("R9 error flag", v & 32'h4, 32'h4);
        rd(3'd2, v); chk("R9 count kept", v, 32'd32);
        rd(3'd3, v); chk("R9 source kept", v, 32'h0000_0100);
        wr(3'd1, 32'h4);
        wr(3'd0, 32'h1);
        wait_idle();
        rd(3'd2, v); chk("R7 resume after error count", v, 32'h0);
        rd(3'd3, v); chk("R7 resume after error source", v, 32'h0000_0120);

        // Halt by clearing start mid-request (R6), resume (R7), busy write ignored (R11).
        mv_delay = 20;
        wr(3'd2, 32'd64);
        wr(3'd3, 32'h0000_8000);
        base = log_n;
        wr(3'd0, 32'h1);
        for (int k = 0; k < 100 && !mv_req; k++) @(negedge clk);
        rd(3'd1, v); chk("R1 busy while running", v & 32'h1, 32'h1);
        wr(3'd0, 32'h0);
        wait_idle();
        chk("R6 one request after halt", 32'(log_n - base), 32'd1);
        rd(3'd2, v); chk("R6 remaining count", v, 32'd48);
        rd(3'd3, v); chk("R6 source progress", v, 32'h0000_8010);
        wr(3'd0, 32'h1);
        repeat (3) @(negedge clk);
        wr(3'd3, 32'hDEAD_0000);
        wait_idle();
        chk("R7 resumed total requests", 32'(log_n - base), 32'd4);
        rd(3'd2, v); chk("R7 resumed count", v, 32'h0);
        rd(3'd3, v); chk("R11 busy write ignored", v, 32'h0000_8040);

        // Same-edge clear and set of the segment flag (R10).
        mv_delay = 4;
        wr(3'd1, 32'h2);
        rd(3'd1, v); chk("R10 segment flag cleared", v & 32'h2, 32'h0);
        wr(3'd2, 32'd16);
        wr(3'd0, 32'h1);
        for (int k = 0; k < 100 && !mv_done; k++) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h2;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle();
        rd(3'd1, v); chk("R10 set wins over clear", v & 32'h2, 32'h2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule